// File: doc/BRIEF.md
# Runtime Polyphase Coefficient Loader

This block lets software replace one phase of a polyphase filter's coefficients while the filter keeps running. Software selects a target bank and phase, writes the tap values into a set of staging registers one word at a time, and then writes a commit register. The low bit of the commit value chooses the horizontal or the vertical coefficient memory. The block then sends the staged taps to that memory over several cycles. Each write carries an address built from bank, phase and tap index.

Every loader register is write-only. A commit takes a private copy of the staging registers, the bank and the phase. Software can therefore start preparing the next phase as soon as the commit is issued. While a transfer runs, a busy output is high and any further commit is dropped. The horizontal and vertical filters may have different tap counts. The direction picked by each commit sets how many taps are sent.

The controller is a two-state machine. `XS_IDLE` waits for a commit. `XS_SEND` emits one tap per cycle. The transition `XS_IDLE -> XS_SEND` fires on a commit write. The transition `XS_SEND -> XS_IDLE` fires in the cycle that emits the last tap of the selected direction. In every other case each state holds.

Top module: `coef_phase_loader`

## Requirements
- R1: After reset, busy and both memory write enables are low, and the bank, phase and all staged taps read as zero in the next transfer.
- R2: A write to byte offset 0x200 sets the target bank from data bits 3:0. A write to 0x204 sets the target phase from data bits 7:0. Higher data bits are ignored.
- R3: Tap i (0 to 63) is staged by a write to byte offset 0x20C + 4*i, and only data bits COEF_W-1:0 are kept. A write to a misaligned or unmapped address, or to a tap index at or above the larger tap count, changes no staged tap.
- R4: A write to byte offset 0x208 is a commit. If data bit 0 is 1, the target is the horizontal memory and H_TAPS taps are sent. If data bit 0 is 0, the target is the vertical memory and V_TAPS taps are sent. All other data bits are ignored.
- R5: After a commit is sampled at a clock edge, taps 0 to N-1 appear on the selected port on N consecutive cycles, starting right after that edge. The address is {bank[3:0], phase[7:0], tap[5:0]} and the data is the staged value at commit time.
- R6: The two memory write enables are never high in the same cycle.
- R7: Busy is high during exactly the N cycles in which taps are written.
- R8: A commit sampled while busy is high is ignored, including one sampled in the cycle that sends the last tap. A commit sampled in the first cycle with busy low is accepted.
- R9: Writes to the staging, bank or phase registers during a transfer do not change the taps, addresses or data being sent. They apply to the next commit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | REG_DW | Register write data |
| busy | output | 1 | High while a transfer is in progress |
| h_coef_we | output | 1 | Horizontal coefficient memory write enable |
| h_coef_addr | output | MEM_AW | Horizontal memory address {bank, phase, tap} |
| h_coef_data | output | COEF_W | Horizontal memory write data |
| v_coef_we | output | 1 | Vertical coefficient memory write enable |
| v_coef_addr | output | MEM_AW | Vertical memory address {bank, phase, tap} |
| v_coef_data | output | COEF_W | Vertical memory write data |

## Verification
Suppose the state machine sticks in the sending state or leaves it one tap early or late. Busy then disagrees with the expected length of N cycles, and a write enable appears with no expected item or an item never arrives. This shows up within one cycle of the transfer's planned end. A wrong tap counter or a wrong latched row shows as a mismatched address on the very first or second write of a transfer. A missing shadow copy shows as corrupted data on the write that follows a staging write made during the transfer. Back-to-back commit bursts check that the busy window matches the acceptance rule at both of its edges.

// File: rtl/coef_ldr_pkg.sv
package coef_ldr_pkg;

    // Byte offsets of the loader's write-only registers
    localparam int unsigned OFS_BANK   = 32'h200;
    localparam int unsigned OFS_PHASE  = 32'h204;
    localparam int unsigned OFS_COMMIT = 32'h208;
    localparam int unsigned OFS_TAP0   = 32'h20C;

    typedef enum logic [0:0] {
        XS_IDLE = 1'b0,
        XS_SEND = 1'b1
    } xfer_state_e;

endpackage

// File: rtl/coef_reg_decode.sv
module coef_reg_decode
    import coef_ldr_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int MAX_TAPS = 64,
    localparam int TAP_W   = $clog2(MAX_TAPS)
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output logic              bank_wr,
    output logic              phase_wr,
    output logic              commit_wr,
    output logic              tap_wr,
    output logic [TAP_W-1:0]  tap_idx
);

    localparam int unsigned TAP_END = OFS_TAP0 + 4 * MAX_TAPS;

    int unsigned a_ext;
    int unsigned tap_off;

    always_comb begin
        a_ext     = {{(32-ADDR_W){1'b0}}, addr};
        tap_off   = a_ext - OFS_TAP0;
        bank_wr   = wr_en && (a_ext == OFS_BANK);
        phase_wr  = wr_en && (a_ext == OFS_PHASE);
        commit_wr = wr_en && (a_ext == OFS_COMMIT);
        tap_wr    = wr_en && (a_ext >= OFS_TAP0) && (a_ext < TAP_END)
                    && (addr[1:0] == 2'b00);
        tap_idx   = tap_off[TAP_W+1:2];
    end

endmodule

// File: rtl/coef_stage_bank.sv
module coef_stage_bank #(
    parameter int COEF_W  = 12,
    parameter int STAGE_N = 8,
    parameter int TAP_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tap_wr,
    input  logic [TAP_W-1:0]  tap_idx,
    input  logic [COEF_W-1:0] tap_val,
    input  logic              snap,
    input  logic [TAP_W-1:0]  rd_idx,
    output logic [COEF_W-1:0] rd_val
);

    logic [COEF_W-1:0] stage_q  [STAGE_N];
    logic [COEF_W-1:0] shadow_q [STAGE_N];

    for (genvar g = 0; g < STAGE_N; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q[g]  <= '0;
                shadow_q[g] <= '0;
            end else begin
                if (tap_wr && (tap_idx == TAP_W'(g))) begin
                    stage_q[g] <= tap_val;
                end
                if (snap) begin
                    shadow_q[g] <= stage_q[g];
                end
            end
        end
    end

    always_comb begin
        rd_val = '0;
        for (int i = 0; i < STAGE_N; i++) begin
            if (rd_idx == TAP_W'(i)) begin
                rd_val = shadow_q[i];
            end
        end
    end

endmodule

// File: rtl/coef_xfer_fsm.sv
module coef_xfer_fsm
    import coef_ldr_pkg::*;
#(
    parameter int TAP_W  = 6,
    parameter int H_TAPS = 8,
    parameter int V_TAPS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit_wr,
    input  logic             commit_h,
    output logic             snap,
    output logic             busy,
    output logic             send_h,
    output logic             send_v,
    output logic [TAP_W-1:0] tap
);

    localparam logic [TAP_W-1:0] H_LAST = TAP_W'(H_TAPS - 1);
    localparam logic [TAP_W-1:0] V_LAST = TAP_W'(V_TAPS - 1);

    xfer_state_e      state_q, state_d;
    logic [TAP_W-1:0] tap_q;
    logic             dir_h_q;
    logic             last_tap;
    logic             accept;

    assign last_tap = (tap_q == (dir_h_q ? H_LAST : V_LAST));
    assign accept   = commit_wr && (state_q == XS_IDLE);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XS_IDLE: if (commit_wr) state_d = XS_SEND;
            XS_SEND: if (last_tap)  state_d = XS_IDLE;
        endcase
    end

    // State register with tap counter and latched direction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= XS_IDLE;
            tap_q   <= '0;
            dir_h_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                tap_q   <= '0;
                dir_h_q <= commit_h;
            end else if (state_q == XS_SEND) begin
                tap_q <= tap_q + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        snap   = accept;
        busy   = 1'b0;
        send_h = 1'b0;
        send_v = 1'b0;
        tap    = tap_q;
        unique case (state_q)
            XS_IDLE: ;
            XS_SEND: begin
                busy   = 1'b1;
                send_h = dir_h_q;
                send_v = !dir_h_q;
            end
        endcase
    end

endmodule

// File: rtl/coef_phase_loader.sv
module coef_phase_loader
    import coef_ldr_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int REG_DW   = 32,
    parameter int COEF_W   = 12,
    parameter int MAX_TAPS = 64,
    parameter int H_TAPS   = 8,
    parameter int V_TAPS   = 4,
    parameter int BANK_W   = 4,
    parameter int PHASE_W  = 8,
    localparam int TAP_W   = $clog2(MAX_TAPS),
    localparam int MEM_AW  = BANK_W + PHASE_W + TAP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic              busy,
    output logic              h_coef_we,
    output logic [MEM_AW-1:0] h_coef_addr,
    output logic [COEF_W-1:0] h_coef_data,
    output logic              v_coef_we,
    output logic [MEM_AW-1:0] v_coef_addr,
    output logic [COEF_W-1:0] v_coef_data
);

    localparam int STAGE_N = (H_TAPS > V_TAPS) ? H_TAPS : V_TAPS;

    logic               bank_wr, phase_wr, commit_wr, tap_wr;
    logic [TAP_W-1:0]   wr_tap_idx;
    logic               snap;
    logic [TAP_W-1:0]   xfer_tap;
    logic [COEF_W-1:0]  xfer_val;
    logic [BANK_W-1:0]  bank_q, row_bank_q;
    logic [PHASE_W-1:0] phase_q, row_phase_q;
    logic [MEM_AW-1:0]  mem_addr;
    logic               unused_wdata;

    assign unused_wdata = ^reg_wdata[REG_DW-1:COEF_W];

    coef_reg_decode #(
        .ADDR_W   (ADDR_W),
        .MAX_TAPS (MAX_TAPS)
    ) u_dec (
        .wr_en     (reg_wr_en),
        .addr      (reg_addr),
        .bank_wr   (bank_wr),
        .phase_wr  (phase_wr),
        .commit_wr (commit_wr),
        .tap_wr    (tap_wr),
        .tap_idx   (wr_tap_idx)
    );

    coef_stage_bank #(
        .COEF_W  (COEF_W),
        .STAGE_N (STAGE_N),
        .TAP_W   (TAP_W)
    ) u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .tap_wr  (tap_wr),
        .tap_idx (wr_tap_idx),
        .tap_val (reg_wdata[COEF_W-1:0]),
        .snap    (snap),
        .rd_idx  (xfer_tap),
        .rd_val  (xfer_val)
    );

    coef_xfer_fsm #(
        .TAP_W  (TAP_W),
        .H_TAPS (H_TAPS),
        .V_TAPS (V_TAPS)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit_wr (commit_wr),
        .commit_h  (reg_wdata[0]),
        .snap      (snap),
        .busy      (busy),
        .send_h    (h_coef_we),
        .send_v    (v_coef_we),
        .tap       (xfer_tap)
    );

    // Target selection registers, and the row copy taken at commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q      <= '0;
            phase_q     <= '0;
            row_bank_q  <= '0;
            row_phase_q <= '0;
        end else begin
            if (bank_wr)  bank_q  <= reg_wdata[BANK_W-1:0];
            if (phase_wr) phase_q <= reg_wdata[PHASE_W-1:0];
            if (snap) begin
                row_bank_q  <= bank_q;
                row_phase_q <= phase_q;
            end
        end
    end

    assign mem_addr    = {row_bank_q, row_phase_q, xfer_tap};
    assign h_coef_addr = mem_addr;
    assign v_coef_addr = mem_addr;
    assign h_coef_data = xfer_val;
    assign v_coef_data = xfer_val;

endmodule

// File: rtl/coef_loader_checker.sv
module coef_loader_checker
    import coef_ldr_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int TAP_W  = 6,
    parameter int MEM_AW = 18,
    parameter int H_TAPS = 8,
    parameter int V_TAPS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_en,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              busy,
    input logic              h_coef_we,
    input logic [MEM_AW-1:0] h_coef_addr,
    input logic              v_coef_we,
    input logic [MEM_AW-1:0] v_coef_addr
);

    logic              any_we;
    logic [TAP_W-1:0]  cur_tap;
    logic [MEM_AW-1:0] cur_addr;
    logic              commit_seen;

    assign any_we      = h_coef_we || v_coef_we;
    assign cur_addr    = h_coef_we ? h_coef_addr : v_coef_addr;
    assign cur_tap     = cur_addr[TAP_W-1:0];
    assign commit_seen = reg_wr_en && (reg_addr == ADDR_W'(OFS_COMMIT));

    AST_SINGLE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        !(h_coef_we && v_coef_we)); // R6

    AST_BUSY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        busy == any_we); // R7

    AST_FIRST_TAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(any_we) |-> (cur_tap == '0)); // R5

    AST_TAP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (any_we && $past(any_we)) |-> (cur_tap == $past(cur_tap) + 1'b1)); // R5

    AST_ROW_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (any_we && $past(any_we)) |->
            (cur_addr[MEM_AW-1:TAP_W] == $past(cur_addr[MEM_AW-1:TAP_W]))); // R9

    AST_COMMIT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_seen && !busy) |=> busy); // R4

    AST_LAST_TAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(cur_tap) ==
            ($past(h_coef_we) ? TAP_W'(H_TAPS - 1) : TAP_W'(V_TAPS - 1)))); // R7

endmodule

bind coef_phase_loader coef_loader_checker #(
    .ADDR_W (ADDR_W),
    .TAP_W  (TAP_W),
    .MEM_AW (MEM_AW),
    .H_TAPS (H_TAPS),
    .V_TAPS (V_TAPS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_en   (reg_wr_en),
    .reg_addr    (reg_addr),
    .busy        (busy),
    .h_coef_we   (h_coef_we),
    .h_coef_addr (h_coef_addr),
    .v_coef_we   (v_coef_we),
    .v_coef_addr (v_coef_addr)
);

// File: tb/tb_coef_phase_loader.sv
module tb_coef_phase_loader;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 12;
    localparam int REG_DW = 32;
    localparam int COEF_W = 12;
    localparam int H_TAPS = 8;
    localparam int V_TAPS = 4;
    localparam int MEM_AW = 18;

    typedef struct packed {
        logic              is_h;
        logic [MEM_AW-1:0] addr;
        logic [COEF_W-1:0] data;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr_en = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [REG_DW-1:0] reg_wdata = '0;
    logic              busy;
    logic              h_coef_we, v_coef_we;
    logic [MEM_AW-1:0] h_coef_addr, v_coef_addr;
    logic [COEF_W-1:0] h_coef_data, v_coef_data;

    int   n_checks = 0;
    int   n_fails  = 0;
    bit   done     = 1'b0;
    int   rem      = 0;
    exp_t exp_q[$];

    logic [COEF_W-1:0] m_stage [64];
    logic [3:0]        m_bank  = '0;
    logic [7:0]        m_phase = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    coef_phase_loader #(
        .ADDR_W (ADDR_W), .REG_DW (REG_DW), .COEF_W (COEF_W),
        .H_TAPS (H_TAPS), .V_TAPS (V_TAPS)
    ) dut (
        .clk (clk), .rst_n (rst_n), .reg_wr_en (reg_wr_en),
        .reg_addr (reg_addr), .reg_wdata (reg_wdata), .busy (busy),
        .h_coef_we (h_coef_we), .h_coef_addr (h_coef_addr), .h_coef_data (h_coef_data),
        .v_coef_we (v_coef_we), .v_coef_addr (v_coef_addr), .v_coef_data (v_coef_data)
    );

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Driver: one register cycle, with the reference model applied
    task automatic step(input logic wen, input logic [ADDR_W-1:0] a,
                        input logic [REG_DW-1:0] d);
        bit accept;
        int n;
        int ai;
        @(negedge clk);
        check(busy === (rem > 0), "R7 busy window", 64'(busy), 64'(rem > 0));
        reg_wr_en = wen;
        reg_addr  = a;
        reg_wdata = d;
        accept = 1'b0;
        ai = int'(a);
        if (wen) begin
            if (ai == 'h200) m_bank = d[3:0];
            else if (ai == 'h204) m_phase = d[7:0];
            else if (ai == 'h208) accept = (rem == 0);
            else if (ai >= 'h20C && ai < 'h20C + 256 && a[1:0] == 2'b00)
                m_stage[(ai - 'h20C) / 4] = d[COEF_W-1:0];
        end
        if (rem > 0) rem--;
        if (accept) begin
            n = d[0] ? H_TAPS : V_TAPS;
            for (int t = 0; t < n; t++)
                exp_q.push_back('{is_h: d[0],
                                  addr: {m_bank, m_phase, 6'(t)},
                                  data: m_stage[t]});
            rem = n;
        end
    endtask

    task automatic idle();
        step(1'b0, '0, '0);
    endtask

    task automatic drain();
        while (rem > 0) idle();
        idle();
        check(exp_q.size() == 0, "R5 all expected taps delivered",
              64'(exp_q.size()), 64'd0);
    endtask

    // Monitor: compares every memory write against the scoreboard
    always @(negedge clk) begin
        if (rst_n && !done && (h_coef_we || v_coef_we)) begin
            exp_t got;
            exp_t want;
            check(!(h_coef_we && v_coef_we), "R6 single port",
                  64'({h_coef_we, v_coef_we}), 64'b01);
            got.is_h = h_coef_we;
            got.addr = h_coef_we ? h_coef_addr : v_coef_addr;
            got.data = h_coef_we ? h_coef_data : v_coef_data;
            if (exp_q.size() == 0) begin
                check(1'b0, "R8 unexpected memory write", 64'(got), 64'd0);
            end else begin
                want = exp_q.pop_front();
                check(got.is_h == want.is_h, "R4 target direction",
                      64'(got.is_h), 64'(want.is_h));
                check(got.addr == want.addr, "R5 address {bank,phase,tap}",
                      64'(got.addr), 64'(want.addr));
                check(got.data == want.data, "R9 tap data",
                      64'(got.data), 64'(want.data));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) m_stage[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(busy === 1'b0, "R1 busy after reset", 64'(busy), 64'd0);
        check(h_coef_we === 1'b0 && v_coef_we === 1'b0, "R1 no writes in reset",
              64'({h_coef_we, v_coef_we}), 64'd0);
        rst_n = 1'b1;

        // R1: commit straight after reset sends zeros to bank 0 phase 0
        step(1'b1, 12'h208, 32'h0);
        drain();

        // R2/R3: wide values, upper bits must be dropped
        step(1'b1, 12'h200, 32'hFFFF_FF1B);
        step(1'b1, 12'h204, 32'h0000_03AB);
        for (int i = 0; i < H_TAPS; i++)
            step(1'b1, 12'(32'h20C + 4 * i), 32'hABCD_E000 | 32'(i * 293 + 17));

        // R4 horizontal, R8 commit during busy, R9 writes during transfer
        step(1'b1, 12'h208, 32'h1);
        step(1'b1, 12'h20C, 32'h0000_0555);
        step(1'b1, 12'h200, 32'h2);
        step(1'b1, 12'h208, 32'h0);
        step(1'b1, 12'h204, 32'h44);
        step(1'b1, 12'h210, 32'h0000_0AAA);
        drain();

        // R4: only bit 0 of commit matters
        step(1'b1, 12'h208, 32'hFFFF_FFFE);
        drain();
        step(1'b1, 12'h208, 32'h0000_0003);
        drain();

        // R3: misaligned, unmapped and beyond-count tap writes are ignored
        step(1'b1, 12'h20D, 32'h0000_0123);
        step(1'b1, 12'h1FC, 32'h0000_0456);
        step(1'b1, 12'h2AC, 32'h0000_0789);
        step(1'b1, 12'h208, 32'h0);
        drain();

        // R8: commit every cycle; acceptance only when idle
        for (int k = 0; k < 24; k++)
            step(1'b1, 12'h208, 32'(k % 3 == 0));
        drain();

        // R5: vertical transfer with a fresh row
        step(1'b1, 12'h200, 32'h7);
        step(1'b1, 12'h204, 32'hC3);
        step(1'b1, 12'h214, 32'h0000_0FED);
        step(1'b1, 12'h208, 32'h0);
        drain();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

endmodule